// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block turns one bus transaction request into the series of double-word addresses that a 64-bit data path moves during the data phase. A request is made of a one-cycle start strobe, the transaction address and a two-bit kind code. When the request is accepted, the sequencer presents beat 0 and then steps to the next beat each time the termination logic sends an advance pulse. A cache line is 32 bytes, so it takes four beats. A single-beat transaction takes one.

The kind code sets the order of the beats. For a cacheable load miss or a cacheable write-back store miss, the first beat is the double-word that holds the requested data, so that data can be forwarded early. The later beats wrap around inside the line. Every other burst, such as a castout or a snoop push, starts at the line-aligned address and counts upward. A burst output is held high for the whole of a four-beat transaction and low for a single-beat one. An abort input drops the sequence at any beat.

Top module: `burst_beat_seq`

## Requirements
- R1: After reset, busy_o, burst_o, last_beat_o and critical_o are 0, and beat_idx_o and beat_addr_o are 0.
- R2: A start_i pulse while idle is accepted at that clock edge. From the next cycle, busy_o=1 and beat_idx_o=0. burst_o is 1 for kind codes 0, 1 and 2, is 0 for code 3, and holds that value until the transaction ends.
- R3: Kind 0 (cacheable load miss) and kind 1 (cacheable write-back store miss) put the double-word-aligned request address (bits [2:0] cleared) on beat 0. critical_o is 1 during beat 0 only.
- R4: Kind 2 (any other burst) puts the 32-byte-aligned address (bits [4:0] cleared) on beat 0, and critical_o stays 0.
- R5: On beat n of a burst, address bits [4:3] equal (start field + n) mod 4. Bits [31:5] keep the request's value and bits [2:0] are 0.
- R6: beat_idx_o rises by one only in a cycle with advance_i. Without advance_i, the index and the address hold.
- R7: last_beat_o is 1 on beat 3 of a burst. An advance on the last beat returns the sequencer to idle in the next cycle.
- R8: Kind 3 (single beat) gives burst_o=0 and last_beat_o=1 from beat 0, with bits [2:0] of the address cleared. One advance ends the transaction.
- R9: abort_i returns the sequencer to idle in the next cycle from any beat. It takes priority over advance_i and over start_i.
- R10: start_i is ignored while busy_o=1. The current sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe |
| abort_i | input | 1 | Drop the current sequence |
| txn_addr_i | input | 32 | Request byte address |
| txn_kind_i | input | 2 | 0 load miss, 1 write-back store miss, 2 other burst, 3 single beat |
| advance_i | input | 1 | Current beat completed |
| busy_o | output | 1 | A sequence is active |
| beat_addr_o | output | 32 | Address of the current beat |
| beat_idx_o | output | 2 | Position of the current beat within the sequence |
| last_beat_o | output | 1 | Current beat is the final one |
| burst_o | output | 1 | 1 for a four-beat transaction, 0 for a single beat |
| critical_o | output | 1 | Current beat carries the critical double-word |

## Verification
The wrap-around from the top double-word back to the bottom of the line only happens when a miss starts near the end of a line. The bench therefore starts a load miss at field 3 and a store miss at field 1, so the wrap falls on beats 1 and 3. An abort that arrives in the same cycle as an advance in the middle of a burst is the other case that is hard to reach. A dedicated scenario drives both inputs together on beat 1, then checks that the sequencer is idle and that a fresh start behaves as it does after reset.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic [1:0] {
      KIND_LOAD_MISS  = 2'd0,
      KIND_STORE_MISS = 2'd1,
      KIND_OTHER      = 2'd2,
      KIND_SINGLE     = 2'd3
   } kind_e;

   function automatic logic is_critical_kind(kind_e k);
      return (k == KIND_LOAD_MISS) || (k == KIND_STORE_MISS);
   endfunction
endpackage

// File: rtl/burst_seq_start_sel.sv
module burst_seq_start_sel
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int OFF_W         = 3,
   parameter int IDX_W         = 2,
   parameter bit CRIT_FIRST_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  kind_e             kind_i,
   output logic [IDX_W-1:0]  start_field_o,
   output logic              burst_o,
   output logic              crit_o
);
   localparam int FLD_LSB = OFF_W;
   localparam int FLD_MSB = OFF_W + IDX_W - 1;

   logic [IDX_W-1:0] req_field;
   assign req_field = addr_i[FLD_MSB:FLD_LSB];
   assign burst_o   = (kind_i != KIND_SINGLE);

   generate
      if (CRIT_FIRST_EN) begin : g_crit_first
         always_comb begin
            crit_o        = is_critical_kind(kind_i);
            start_field_o = (crit_o || !burst_o) ? req_field : '0;
         end
      end else begin : g_line_first
         always_comb begin
            crit_o        = 1'b0;
            start_field_o = burst_o ? '0 : req_field;
         end
      end
   endgenerate

   always_comb begin
      a_r4_other_aligned: assert (!(burst_o && !crit_o) || start_field_o == '0)
         else $error("a_r4_other_aligned: non-critical burst must start line aligned");
   end
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl #(
   parameter int LINE_BEATS = 4,
   parameter int IDX_W      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             abort_i,
   input  logic             advance_i,
   input  logic             burst_req_i,
   input  logic             crit_req_i,
   output logic             accept_o,
   output logic             busy_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             last_o,
   output logic             burst_o,
   output logic             critical_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_BEATS - 1);

   logic             busy_q;
   logic [IDX_W-1:0] idx_q;
   logic             burst_q;
   logic             crit_q;

   assign accept_o = start_i && !busy_q && !abort_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         idx_q   <= '0;
         burst_q <= 1'b0;
         crit_q  <= 1'b0;
      end else if (abort_i) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q  <= 1'b1;
            idx_q   <= '0;
            burst_q <= burst_req_i;
            crit_q  <= crit_req_i;
         end
      end else if (advance_i) begin
         if (last_o) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign busy_o     = busy_q;
   assign idx_o      = idx_q;
   assign burst_o    = busy_q && burst_q;
   assign last_o     = busy_q && (!burst_q || idx_q == LAST_IDX);
   assign critical_o = busy_q && crit_q && (idx_q == '0);

   a_r6_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !advance_i && !abort_i |=> $stable(idx_o) && busy_o)
      else $error("a_r6_idx_hold");
   a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && last_o && advance_i && !abort_i |=> !busy_o)
      else $error("a_r7_last_ends");
   a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> !busy_o)
      else $error("a_r9_abort_idle");
   a_r2_burst_steady: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !abort_i && !last_o |=> $stable(burst_o))
      else $error("a_r2_burst_steady");
   a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i && !advance_i && !abort_i |=> $stable(idx_o) && $stable(burst_o))
      else $error("a_r10_start_ignored");
   a_r3_crit_first_only: assert property (@(posedge clk) disable iff (!rst_n)
      critical_o |-> idx_o == '0 && busy_o)
      else $error("a_r3_crit_first_only");
   a_r8_single_last: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !burst_o |-> last_o)
      else $error("a_r8_single_last");
endmodule

// File: rtl/burst_seq_addr_gen.sv
module burst_seq_addr_gen #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 3,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [IDX_W-1:0]  start_field_i,
   input  logic              busy_i,
   input  logic              advance_i,
   input  logic              abort_i,
   input  logic              last_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [ADDR_W-1:0] beat_addr_o
);
   localparam int LINE_LSB = OFF_W + IDX_W;
   localparam int LINE_W   = ADDR_W - LINE_LSB;

   logic [LINE_W-1:0] line_q;
   logic [IDX_W-1:0]  start_q;
   logic [IDX_W-1:0]  field;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q  <= '0;
         start_q <= '0;
      end else if (accept_i) begin
         line_q  <= addr_i[ADDR_W-1:LINE_LSB];
         start_q <= start_field_i;
      end
   end

   // modulo wrap falls out of the IDX_W-bit addition
   assign field       = start_q + idx_i;
   assign beat_addr_o = busy_i ? {line_q, field, {OFF_W{1'b0}}} : '0;

   a_r5_line_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i && advance_i && !last_i && !abort_i
      |=> beat_addr_o[ADDR_W-1:LINE_LSB] == $past(beat_addr_o[ADDR_W-1:LINE_LSB]))
      else $error("a_r5_line_fixed");
   a_r5_field_step: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i && advance_i && !last_i && !abort_i
      |=> beat_addr_o[LINE_LSB-1:OFF_W] == $past(beat_addr_o[LINE_LSB-1:OFF_W]) + 1'b1)
      else $error("a_r5_field_step");
endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int BEAT_BYTES    = 8,
   parameter int LINE_BEATS    = 4,
   parameter bit CRIT_FIRST_EN = 1'b1,
   localparam int IDX_W        = $clog2(LINE_BEATS),
   localparam int OFF_W        = $clog2(BEAT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic [ADDR_W-1:0] txn_addr_i,
   input  logic [1:0]        txn_kind_i,
   input  logic              advance_i,
   output logic              busy_o,
   output logic [ADDR_W-1:0] beat_addr_o,
   output logic [IDX_W-1:0]  beat_idx_o,
   output logic              last_beat_o,
   output logic              burst_o,
   output logic              critical_o
);
   generate
      if (LINE_BEATS < 2 || (1 << IDX_W) != LINE_BEATS) begin : g_bad_beats
         $error("LINE_BEATS must be a power of two of at least 2");
      end
      if (BEAT_BYTES < 1 || (1 << OFF_W) != BEAT_BYTES) begin : g_bad_bytes
         $error("BEAT_BYTES must be a power of two");
      end
      if (ADDR_W <= OFF_W + IDX_W) begin : g_bad_addr
         $error("ADDR_W too narrow for one line");
      end
   endgenerate

   kind_e            kind;
   logic [IDX_W-1:0] start_field;
   logic             burst_req;
   logic             crit_req;
   logic             accept;

   assign kind = kind_e'(txn_kind_i);

   burst_seq_start_sel #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .CRIT_FIRST_EN(CRIT_FIRST_EN)
   ) u_start_sel (
      .addr_i(txn_addr_i), .kind_i(kind),
      .start_field_o(start_field), .burst_o(burst_req), .crit_o(crit_req)
   );

   burst_seq_ctrl #(.LINE_BEATS(LINE_BEATS), .IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
      .advance_i(advance_i), .burst_req_i(burst_req), .crit_req_i(crit_req),
      .accept_o(accept), .busy_o(busy_o), .idx_o(beat_idx_o),
      .last_o(last_beat_o), .burst_o(burst_o), .critical_o(critical_o)
   );

   burst_seq_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .accept_i(accept), .addr_i(txn_addr_i),
      .start_field_i(start_field), .busy_i(busy_o), .advance_i(advance_i),
      .abort_i(abort_i), .last_i(last_beat_o), .idx_i(beat_idx_o),
      .beat_addr_o(beat_addr_o)
   );

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !burst_o && !last_beat_o && !critical_o && beat_addr_o == '0)
      else $error("a_r1_idle_quiet");
endmodule

// File: tb/burst_beat_seq_bench.sv
module burst_beat_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        abort_i = 1'b0;
   logic [31:0] txn_addr_i = '0;
   logic [1:0]  txn_kind_i = '0;
   logic        advance_i = 1'b0;
   logic        busy_o;
   logic [31:0] beat_addr_o;
   logic [1:0]  beat_idx_o;
   logic        last_beat_o;
   logic        burst_o;
   logic        critical_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   burst_beat_seq u_burst_beat_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
      .txn_addr_i(txn_addr_i), .txn_kind_i(txn_kind_i), .advance_i(advance_i),
      .busy_o(busy_o), .beat_addr_o(beat_addr_o), .beat_idx_o(beat_idx_o),
      .last_beat_o(last_beat_o), .burst_o(burst_o), .critical_o(critical_o)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   // one clock edge, inputs released just after it, outputs settled
   task automatic step();
      @(posedge clk);
      #2;
      start_i   = 1'b0;
      abort_i   = 1'b0;
      advance_i = 1'b0;
   endtask

   function automatic logic [31:0] exp_addr(logic [31:0] a, logic [1:0] k, int n);
      logic [1:0] f;
      if (k < 2)       f = a[4:3] + 2'(n);
      else if (k == 2) f = 2'(n);
      else             f = a[4:3];
      return {a[31:5], f, 3'b000};
   endfunction

   task automatic launch(logic [31:0] a, logic [1:0] k);
      txn_addr_i = a;
      txn_kind_i = k;
      start_i    = 1'b1;
      step();
   endtask

   // full four-beat burst with checks on every beat
   task automatic run_burst(string req, logic [31:0] a, logic [1:0] k);
      launch(a, k);
      for (int n = 0; n < 4; n++) begin
         chk("R2", {req, " busy"}, 32'(busy_o), 1);
         chk("R2", {req, " burst"}, 32'(burst_o), 1);
         chk("R6", {req, " idx"}, 32'(beat_idx_o), n);
         chk("R5", {req, " addr"}, beat_addr_o, exp_addr(a, k, n));
         chk("R3", {req, " critical"}, 32'(critical_o), (k < 2 && n == 0) ? 1 : 0);
         chk("R7", {req, " last"}, 32'(last_beat_o), (n == 3) ? 1 : 0);
         advance_i = 1'b1;
         step();
      end
      chk("R7", {req, " idle after last"}, 32'(busy_o), 0);
   endtask

   task automatic t_reset();
      chk("R1", "busy", 32'(busy_o), 0);
      chk("R1", "burst", 32'(burst_o), 0);
      chk("R1", "last", 32'(last_beat_o), 0);
      chk("R1", "critical", 32'(critical_o), 0);
      chk("R1", "idx", 32'(beat_idx_o), 0);
      chk("R1", "addr", beat_addr_o, 0);
   endtask

   task automatic t_load_wrap();
      launch(32'h1234_5678 | 32'h18, 2'd0);
      chk("R3", "load beat0 addr", beat_addr_o, 32'h1234_5678 & 32'hFFFF_FFF8 | 32'h18);
      // drop the launch and replay as a full checked burst
      abort_i = 1'b1;
      step();
      run_burst("R3 load", 32'h1234_567D, 2'd0);
   endtask

   task automatic t_store_gaps();
      logic [31:0] a = 32'hABCD_EF0B;
      launch(a, 2'd1);
      for (int n = 0; n < 4; n++) begin
         for (int g = 0; g < 2; g++) begin
            chk("R6", "store idx held", 32'(beat_idx_o), n);
            chk("R5", "store addr", beat_addr_o, exp_addr(a, 2'd1, n));
            if (g == 0) step();
         end
         chk("R3", "store critical", 32'(critical_o), (n == 0) ? 1 : 0);
         advance_i = 1'b1;
         step();
      end
      chk("R7", "store idle", 32'(busy_o), 0);
   endtask

   task automatic t_other();
      run_burst("R4 other", 32'h0000_F0F4, 2'd2);
      launch(32'h0000_F0F4, 2'd2);
      chk("R4", "other beat0 aligned", beat_addr_o, 32'h0000_F0E0);
      abort_i = 1'b1;
      step();
   endtask

   task automatic t_single();
      launch(32'h4000_0015, 2'd3);
      chk("R8", "single busy", 32'(busy_o), 1);
      chk("R8", "single burst", 32'(burst_o), 0);
      chk("R8", "single last", 32'(last_beat_o), 1);
      chk("R8", "single addr", beat_addr_o, 32'h4000_0010);
      chk("R8", "single critical", 32'(critical_o), 0);
      step();
      chk("R8", "single waits", 32'(busy_o), 1);
      advance_i = 1'b1;
      step();
      chk("R8", "single done", 32'(busy_o), 0);
   endtask

   task automatic t_abort();
      launch(32'h0000_1008, 2'd0);
      advance_i = 1'b1;
      step();
      chk("R9", "pre-abort idx", 32'(beat_idx_o), 1);
      abort_i   = 1'b1;
      advance_i = 1'b1;
      step();
      chk("R9", "abort busy", 32'(busy_o), 0);
      chk("R9", "abort burst", 32'(burst_o), 0);
      chk("R9", "abort idx", 32'(beat_idx_o), 0);
      run_burst("R9 restart", 32'h0000_2010, 2'd2);
   endtask

   task automatic t_start_busy();
      launch(32'h0000_3000, 2'd2);
      advance_i = 1'b1;
      step();
      txn_addr_i = 32'h7777_7718;
      txn_kind_i = 2'd3;
      start_i    = 1'b1;
      step();
      chk("R10", "idx kept", 32'(beat_idx_o), 1);
      chk("R10", "burst kept", 32'(burst_o), 1);
      chk("R10", "addr kept", beat_addr_o, 32'h0000_3008);
      advance_i = 1'b1; step();
      advance_i = 1'b1; step();
      chk("R10", "last reached", 32'(last_beat_o), 1);
      advance_i = 1'b1; step();
      chk("R10", "finished", 32'(busy_o), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      t_reset();
      t_load_wrap();
      t_store_gaps();
      t_other();
      t_single();
      t_abort();
      t_start_busy();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule